// File: doc/BRIEF.md
# Two-Way Register-File DMA Channel

This block is one DMA channel that copies bytes between a register-file RAM with 12-bit addresses and the on-chip peripheral control registers, which sit in the top page of the same address space. Software sets it up through five byte-wide configuration registers. These hold the peripheral address byte, a shared high-nibble byte that supplies the top nibble of both the start and end RAM addresses, the start/current pointer, the end pointer and a control byte. The control byte sets the direction, loop or single-pass operation, one or two bytes per trigger, the trigger line, interrupt enable and channel enable.

Each accepted trigger runs one transfer. The channel raises `bus_req` and holds it. It waits for `bus_ack`, then runs a read cycle and a write cycle for each byte, and then drops the request. Back-pressure on the system bus comes only from `bus_ack`. While the acknowledge stays low the channel holds in its request state and issues no access. Once granted, the acknowledge must stay high until the request falls.

After each transfer the pointer either moves forward or reaches the end address. At the end, loop mode restarts from the start address and single-pass mode switches the channel off. An interrupt pulse marks the end of a pass.

Top module: `dma_chan`

## Requirements
- R1: After reset all five configuration registers read 0, and `bus_req`, `bus_rd`, `bus_wr` and `irq` are low.
- R2: `cfg_sel` selects the register: 0 = peripheral byte, 1 = high nibbles, 2 = start/current, 3 = end, 4 = control. A write with `cfg_we` lands at the next clock edge and reads back on `cfg_rdata`. Writing select 2 loads both the saved start value and the current pointer. Control bits are: bit0 enable, bit1 direction (1 = RAM to peripheral, 0 = peripheral to RAM), bit2 loop, bit3 word, bit4 interrupt enable, bits 6:5 trigger line. Bit 7 reads 0.
- R3: The RAM address of byte k (k = 0 or 1) is {HIGH[3:0], CUR+k}. The peripheral address is {4'hF, IO+k}, with each low byte taken modulo 256. The end address is {HIGH[7:4], END}.
- R4: A transfer starts only when the channel is idle and enabled and trigger line `trig[CTL[6:5]]` is high at a clock edge. Other lines, and triggers while the channel is disabled, cause no bus request.
- R5: `bus_req` stays high from the cycle after the trigger until the last write is done. `bus_rd` and `bus_wr` are asserted only while both `bus_req` and `bus_ack` are high, never together. While `bus_ack` is low the channel waits.
- R6: Each byte takes one read cycle at the source address, then one write cycle at the destination address. The write carries the `bus_rdata` value sampled during the read cycle. The direction bit picks which side is the source.
- R7: In word mode a trigger moves byte 0 and then byte 1, at offset 0 and offset +1 on both sides.
- R8: A transfer reaches the end when {0,HIGH[3:0],CUR} + word >= {0,HIGH[7:4],END}, compared as 13-bit values. If it does not, CUR advances by 1 (byte mode) or 2 (word mode), modulo 256.
- R9: When the end is reached in loop mode, CUR reloads from the value last written to select 2, and the channel stays enabled.
- R10: When the end is reached in single-pass mode, the enable bit clears and CUR stays unchanged. Later triggers are ignored.
- R11: `irq` pulses high for exactly one cycle after a transfer that reaches the end, if interrupt enable is set. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected register contents |
| trig | input | 4 | Trigger request lines |
| bus_req | output | 1 | System bus request |
| bus_ack | input | 1 | System bus grant |
| bus_addr | output | 12 | Bus address during read or write cycles |
| bus_rd | output | 1 | Read cycle |
| bus_rdata | input | 8 | Read data, valid in the read cycle |
| bus_wr | output | 1 | Write cycle |
| bus_wdata | output | 8 | Write data |
| irq | output | 1 | End-of-pass interrupt pulse |

## Verification
The embedded properties check the bus protocol on every cycle. Accesses happen only under request and grant, never two at once, and the channel waits while the grant is low. Write data matches the previous read, and the interrupt lasts a single cycle. They also check each pointer outcome at the end of a transfer: the advance, the loop reload and the single-pass disable.

Only the bench scenarios can show that the right bytes arrive at the right addresses in both directions and in word mode. The same goes for the end-address compare across nibble boundaries and for ignored triggers on unselected lines or a disabled channel. The bench checks these against its own model of the register file and peripheral page.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned ADDR_W = NIB_W + DATA_W;
  localparam int unsigned TSEL_W = 2;
  localparam int unsigned N_TRIG = 1 << TSEL_W;
  localparam int unsigned SEL_W  = 3;
  localparam logic [NIB_W-1:0] PERIPH_PAGE = 4'hF;

  localparam logic [SEL_W-1:0] SEL_IO  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_HI  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CUR = 3'd2;
  localparam logic [SEL_W-1:0] SEL_END = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CTL = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_WR,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic [TSEL_W-1:0] tsel;
    logic              irq_en;
    logic              word;
    logic              loop;
    logic              to_periph;
    logic              enable;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              adv,
  output logic [DATA_W-1:0] rdata,
  output ctl_t              ctl,
  output logic [DATA_W-1:0] io_q,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] cur_q,
  output logic              end_hit
);
  logic [DATA_W-1:0] start_q, end_q;
  logic [DATA_W-1:0] step;
  logic [ADDR_W:0]   tail, limit;

  assign step    = ctl.word ? DATA_W'(2) : DATA_W'(1);
  assign tail    = {1'b0, hi_q[NIB_W-1:0], cur_q} + (ADDR_W+1)'(ctl.word);
  assign limit   = {1'b0, hi_q[DATA_W-1:NIB_W], end_q};
  assign end_hit = tail >= limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_q    <= '0;
      hi_q    <= '0;
      start_q <= '0;
      cur_q   <= '0;
      end_q   <= '0;
      ctl     <= '0;
    end else if (we) begin
      case (sel)
        SEL_IO:  io_q <= wdata;
        SEL_HI:  hi_q <= wdata;
        SEL_CUR: begin
          start_q <= wdata;
          cur_q   <= wdata;
        end
        SEL_END: end_q <= wdata;
        SEL_CTL: ctl   <= ctl_t'(wdata[CTL_W-1:0]);
        default: ;
      endcase
    end else if (adv) begin
      if (!end_hit)      cur_q      <= cur_q + step;
      else if (ctl.loop) cur_q      <= start_q;
      else               ctl.enable <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_IO:  rdata = io_q;
      SEL_HI:  rdata = hi_q;
      SEL_CUR: rdata = cur_q;
      SEL_END: rdata = end_q;
      SEL_CTL: rdata = DATA_W'(ctl);
      default: rdata = '0;
    endcase
  end

  a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !we && !end_hit) |=> (cur_q == $past(cur_q) + $past(step)));
  a_r9_loop_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !we && end_hit && ctl.loop) |=> (cur_q == start_q && ctl.enable == $past(ctl.enable)));
  a_r10_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !we && end_hit && !ctl.loop) |=> (!ctl.enable && $stable(cur_q)));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] io_q,
  input  logic [DATA_W-1:0] hi_q,
  input  logic [DATA_W-1:0] cur_q,
  input  logic              end_hit,
  input  logic [N_TRIG-1:0] trig,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              adv,
  output logic              irq
);
  seq_state_t        state;
  logic              second;
  logic [DATA_W-1:0] data_q;
  logic              fire;
  logic [ADDR_W-1:0] ram_a, per_a;

  assign fire  = (state == ST_IDLE) && ctl.enable && trig[ctl.tsel];
  assign ram_a = {hi_q[NIB_W-1:0], cur_q + DATA_W'(second)};
  assign per_a = {PERIPH_PAGE, io_q + DATA_W'(second)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      second <= 1'b0;
      data_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (fire) state <= ST_REQ;
        ST_REQ:  if (bus_ack) state <= ST_RD;
        ST_RD: begin
          data_q <= bus_rdata;
          state  <= ST_WR;
        end
        ST_WR: begin
          if (ctl.word && !second) begin
            second <= 1'b1;
            state  <= ST_RD;
          end else begin
            state  <= ST_DONE;
          end
        end
        ST_DONE: begin
          second <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_addr = '0;
    if (state == ST_RD)      bus_addr = ctl.to_periph ? ram_a : per_a;
    else if (state == ST_WR) bus_addr = ctl.to_periph ? per_a : ram_a;
  end

  assign bus_req   = (state == ST_REQ) || (state == ST_RD) || (state == ST_WR);
  assign bus_rd    = (state == ST_RD);
  assign bus_wr    = (state == ST_WR);
  assign bus_wdata = data_q;
  assign adv       = (state == ST_DONE);
  assign irq       = (state == ST_DONE) && end_hit && ctl.irq_en;

  a_r5_granted_access: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> (bus_req && bus_ack));
  a_r5_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));
  a_r5_wait_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && !bus_ack) |=> (state == ST_REQ));
  a_r4_req_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(fire));
  a_r6_wdata_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_wr && bus_wdata == $past(bus_rdata)));
  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [N_TRIG-1:0] trig,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              irq
);
  ctl_t              ctl;
  logic [DATA_W-1:0] io_q, hi_q, cur_q;
  logic              end_hit, adv;

  dma_chan_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .wdata   (cfg_wdata),
    .adv     (adv),
    .rdata   (cfg_rdata),
    .ctl     (ctl),
    .io_q    (io_q),
    .hi_q    (hi_q),
    .cur_q   (cur_q),
    .end_hit (end_hit)
  );

  dma_chan_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .io_q      (io_q),
    .hi_q      (hi_q),
    .cur_q     (cur_q),
    .end_hit   (end_hit),
    .trig      (trig),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .adv       (adv),
    .irq       (irq)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> (!bus_req && !bus_rd && !bus_wr && !irq));
endmodule

// File: tb/dma_chan_bench.sv
`timescale 1ns/1ps
module dma_chan_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [7:0] cfg_rdata;
  logic [3:0] trig = 4'd0;
  logic       bus_req;
  logic       bus_ack = 1'b0;
  logic [11:0] bus_addr;
  logic       bus_rd, bus_wr, irq;
  logic [7:0] bus_rdata, bus_wdata;

  logic [7:0] mem [4096];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] m_io, m_hi, m_start, m_cur, m_end;
  logic [6:0] m_ctl;

  always #2 clk = ~clk;

  dma_chan u_dma_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig(trig),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .irq(irq)
  );

  assign bus_rdata = mem[bus_addr];
  always @(posedge clk) if (bus_wr) mem[bus_addr] <= bus_wdata;
  always @(negedge clk) bus_ack = bus_req ? (bus_ack | ($urandom % 3 == 0)) : 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    cfg_sel = s;
    #1 d = cfg_rdata;
  endtask

  task automatic setup(input logic [7:0] io, input logic [7:0] hi, input logic [7:0] st,
                       input logic [7:0] en, input logic [6:0] ctl);
    wr_reg(3'd0, io); wr_reg(3'd1, hi); wr_reg(3'd2, st); wr_reg(3'd3, en);
    wr_reg(3'd4, {1'b0, ctl});
    m_io = io; m_hi = hi; m_start = st; m_cur = st; m_end = en; m_ctl = ctl;
  endtask

  function automatic bit model_hit();
    logic [12:0] tail;
    tail = {1'b0, m_hi[3:0], m_cur} + 13'(m_ctl[3]);
    return tail >= {1'b0, m_hi[7:4], m_end};
  endfunction

  task automatic xfer(input int line);
    logic [11:0] src [2];
    logic [11:0] dst [2];
    logic [7:0]  ev [2];
    logic [7:0]  rv;
    int nb, irqs;
    bit act, hit, saw, closed;
    act = m_ctl[0] && (line == int'(m_ctl[6:5]));
    nb  = m_ctl[3] ? 2 : 1;
    for (int k = 0; k < 2; k++) begin
      logic [11:0] ra, pa;
      ra = {m_hi[3:0], 8'(m_cur + 8'(k))};
      pa = {4'hF, 8'(m_io + 8'(k))};
      src[k] = m_ctl[1] ? ra : pa;
      dst[k] = m_ctl[1] ? pa : ra;
      ev[k]  = mem[src[k]];
    end
    hit = model_hit();
    @(negedge clk); trig[line] = 1'b1;
    @(negedge clk); trig = 4'd0;
    saw = 0; closed = 0; irqs = 0;
    for (int c = 0; c < 40 && !closed; c++) begin
      if (irq) irqs++;
      if (bus_req) saw = 1;
      else if (saw) closed = 1;
      if (!closed) @(negedge clk);
    end
    @(negedge clk);
    if (irq) irqs++;
    chk(saw == act, "R4 trigger accepted", saw, act);
    chk(!saw || closed, "R5 request released", closed, 1);
    if (act) begin
      for (int k = 0; k < nb; k++)
        chk(mem[dst[k]] == ev[k], m_ctl[3] ? "R7 word byte" : "R6 byte moved",
            mem[dst[k]], ev[k]);
      if (!hit) m_cur = m_cur + 8'(nb);
      else if (m_ctl[2]) m_cur = m_start;
      else m_ctl[0] = 1'b0;
    end
    chk(irqs == ((act && hit && m_ctl[4]) ? 1 : 0), "R11 interrupt pulse",
        irqs, (act && hit && m_ctl[4]) ? 1 : 0);
    rd_reg(3'd2, rv);
    chk(rv == m_cur, act && hit ? (m_ctl[2] ? "R9 loop reload" : "R10 pointer held")
                                : "R8 pointer advance", rv, m_cur);
    rd_reg(3'd4, rv);
    chk(rv == {1'b0, m_ctl}, "R10 control enable", rv, {1'b0, m_ctl});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 5; s++) begin
      rd_reg(3'(s), rv);
      chk(rv == 8'd0, "R1 register reset", rv, 0);
    end
    chk(!bus_req && !bus_rd && !bus_wr && !irq, "R1 outputs idle",
        {bus_req, bus_rd, bus_wr, irq}, 0);
    // R2 readback of each register
    setup(8'h3C, 8'h21, 8'h10, 8'h14, 7'b00_1_0_1_0_0);
    rd_reg(3'd0, rv); chk(rv == 8'h3C, "R2 io readback", rv, 8'h3C);
    rd_reg(3'd1, rv); chk(rv == 8'h21, "R2 high readback", rv, 8'h21);
    rd_reg(3'd2, rv); chk(rv == 8'h10, "R2 start readback", rv, 8'h10);
    rd_reg(3'd3, rv); chk(rv == 8'h14, "R2 end readback", rv, 8'h14);
    rd_reg(3'd4, rv); chk(rv == 8'h14, "R2 control readback", rv, 8'h14);
    // R4 disabled channel ignores trigger
    xfer(0);
    // R3 R6 peripheral to RAM, byte, single pass to end on line 2
    setup(8'hFE, 8'h55, 8'hFE, 8'hFF, 7'b10_1_0_0_0_1);
    xfer(1);
    xfer(2); xfer(2); xfer(2);
    // R7 word mode, RAM to peripheral, loop with irq, io wraps in page
    setup(8'hFF, 8'h33, 8'h20, 8'h23, 7'b01_1_1_1_1_1);
    for (int n = 0; n < 5; n++) xfer(1);
    // R8 end compare across nibbles: start page 2 below end page 3
    setup(8'h40, 8'h32, 8'hFE, 8'h00, 7'b00_1_1_0_0_1);
    for (int n = 0; n < 3; n++) xfer(0);
    // constrained random scenarios
    for (int it = 0; it < 60; it++) begin
      logic [3:0] p;
      logic [7:0] st, ln;
      p  = 4'($urandom % 15);
      st = 8'($urandom);
      ln = 8'($urandom % 9);
      setup(8'($urandom), ($urandom % 4 == 0) ? {4'($urandom % 15), p} : {p, p}, st,
            (int'(st) + int'(ln) > 255) ? 8'hFF : st + ln,
            {2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom % 8 != 0)});
      for (int n = 0; n < 1 + int'($urandom % 6); n++)
        xfer(($urandom % 4 == 0) ? int'($urandom % 4) : int'(m_ctl[6:5]));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule